// File: doc/BRIEF.md
# Digital Soft-Start Slew Limiter

This block produces the digital reference code for a regulator's output-voltage DAC. A single up/down counter moves the code one LSB at a time toward a target voltage-ID (VID) code. A rate oscillator paces each step. At start-up the ramp follows one of two profiles, chosen by a mode input. In the direct profile the code climbs from zero straight to the VID. In the boot profile the code first climbs to a fixed boot code, holds there for a pause, then moves up or down to whatever VID is current when the pause ends.

Soft-start steps use one period. Once start-up has finished, the counter keeps tracking VID changes using a slower slew period chosen by the mode. A rate-select input scales every period by a power of two. The VID input is synchronised and filtered before use. Each accepted VID change restarts the oscillator phase, so the first slew step always lands a fixed number of cycles after the change.

Top module: `dac_ramp_top`

## Requirements
- R1: Under reset, and one clock edge after `en` is sampled low, `dac_code` is 0 and `ss_active` and `ss_done` are both 0.
- R2: `dac_code` never changes by more than one LSB between consecutive cycles while enabled.
- R3: With `mode_sel`=0 and a settled VID T, counting the edge that first samples `en`=1 as edge 0, the code after edge j is min(floor(j/P), T) with P = SS_PERIOD shifted left by `rate_sel`. `ss_done` rises at edge (T+1)*P.
- R4: With `mode_sel`=1, the code climbs to BOOT_CODE as in R3 and holds until edge (BOOT_CODE+1)*P. It then stays there for PAUSE_CYC cycles, and after that steps toward the VID one LSB per P cycles, up or down. `ss_done` rises (|T-BOOT_CODE|+1)*P edges after the pause ends.
- R5: A VID change accepted during the boot ramp or pause does not move the code off the boot path. The final ramp targets the latest accepted VID.
- R6: The step period is SS_PERIOD shifted left by `rate_sel` until `ss_done`. After that it is SLEW_PERIOD_DIRECT (mode 0) or SLEW_PERIOD_BOOT (mode 1), shifted the same way.
- R7: A new `vid_in` value present first at edge k and held is accepted at edge k+3. The oscillator phase restarts at that edge, so after `ss_done` the code takes its m-th step toward the new value at edge k+3+m*Ps, where Ps is the slew period.
- R8: A `vid_in` value that lasts a single cycle is never accepted and leaves `dac_code` unchanged.
- R9: `ss_active` is 1 from edge 0 until the edge where `ss_done` rises. `ss_done` then stays 1 until `en` falls, and the two flags are never 1 together.
- R10: After `ss_done`, the code follows later VID changes in both directions and settles exactly on the new VID.
- R11: If a VID acceptance falls on the same edge that sets `ss_done`, `ss_done` still rises there with the code at the old target. From that edge the code slews to the new VID at the slew period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low clears the code and returns to idle |
| mode_sel | input | 1 | Start-up profile: 0 direct, 1 boot level with pause (latched at start) |
| rate_sel | input | RATE_W | Left shift applied to every step period |
| vid_in | input | CODE_W | Target VID code, asynchronous to the ramp |
| dac_code | output | CODE_W | Current DAC reference code |
| ss_active | output | 1 | Soft-start in progress |
| ss_done | output | 1 | Soft-start complete, slew tracking active |

## Verification
Two events can land on the same clock edge: the oscillator tick that finishes soft-start, and the acceptance of a new VID, which restarts the oscillator phase and changes the target. The bench provokes this by applying the new VID exactly three edges before the computed completion edge. It then requires `ss_done` to rise on that edge with the code still at the old target, and it predicts every later step from that same edge at the slew period. Every other trajectory in the sweeps over mode, rate and target is also predicted cycle by cycle from arithmetic on the periods.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOOT,
    ST_PAUSE,
    ST_FINAL,
    ST_RUN
  } ramp_state_e;

endpackage

// File: rtl/vid_filter.sv
module vid_filter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vid_in,
  output logic [CODE_W-1:0] vid_acc,
  output logic              vid_chg
);

  logic [CODE_W-1:0] sync_a, sync_b, sync_c;

  // accept only a value seen on two consecutive synchronised samples
  assign vid_chg = (sync_b == sync_c) && (sync_b != vid_acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a  <= '0;
      sync_b  <= '0;
      sync_c  <= '0;
      vid_acc <= '0;
    end else begin
      sync_a <= vid_in;
      sync_b <= sync_a;
      sync_c <= sync_b;
      if (vid_chg) vid_acc <= sync_b;
    end
  end

  // R7 / R8: an accepted value was present on the pin for two cycles in a row
  p_accept_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(vid_acc) |-> (($past(vid_in, 3) == $past(vid_in, 4)) && (vid_acc == $past(vid_in, 3))));

endmodule

// File: rtl/step_osc.sv
module step_osc #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [PER_W-1:0] period,
  output logic             tick
);

  logic [PER_W-1:0] cnt_q;

  // period 0 behaves as 1
  assign tick = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R7: a phase restart delays the next step by a full period
  p_phase_restart_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && (period > 1)) |-> !tick);

endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
  import ssr_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int BOOT_CODE = 100,
  parameter int PAUSE_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode_sel,
  input  logic [CODE_W-1:0] vid_tgt,
  input  logic              tick,
  output logic [CODE_W-1:0] code_q,
  output logic              active_q,
  output logic              done_q,
  output logic              mode_q,
  output logic              phase_rst
);

  localparam int PC_W = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC + 1) : 1;
  localparam logic [CODE_W-1:0] BOOT_V     = CODE_W'(BOOT_CODE);
  localparam logic [PC_W-1:0]   PAUSE_LAST = PC_W'(PAUSE_CYC - 1);

  ramp_state_e       st_q, st_n;
  logic [PC_W-1:0]   pcnt_q;
  logic [CODE_W-1:0] goal, code_n;
  logic              moving;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:  if (en) st_n = mode_sel ? ST_BOOT : ST_FINAL;
      ST_BOOT:  if (tick && (code_q == BOOT_V)) st_n = ST_PAUSE;
      ST_PAUSE: if (pcnt_q == PAUSE_LAST) st_n = ST_FINAL;
      ST_FINAL: if (tick && (code_q == vid_tgt)) st_n = ST_RUN;
      ST_RUN:   st_n = ST_RUN;
      default:  st_n = ST_IDLE;
    endcase
    if (!en) st_n = ST_IDLE;
  end

  // boot path ignores the VID until the pause has elapsed
  assign goal   = ((st_q == ST_BOOT) || (st_q == ST_PAUSE)) ? BOOT_V : vid_tgt;
  assign moving = tick && ((st_q == ST_BOOT) || (st_q == ST_FINAL) || (st_q == ST_RUN));

  always_comb begin
    code_n = code_q;
    if (moving) begin
      if (code_q < goal)      code_n = code_q + 1'b1;
      else if (code_q > goal) code_n = code_q - 1'b1;
    end
  end

  assign phase_rst = (st_n != st_q);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q     <= ST_IDLE;
      code_q   <= '0;
      pcnt_q   <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      code_q   <= code_n;
      pcnt_q   <= (st_q == ST_PAUSE) ? pcnt_q + 1'b1 : '0;
      active_q <= (st_n == ST_BOOT) || (st_n == ST_PAUSE) || (st_n == ST_FINAL);
      done_q   <= done_q || ((st_q == ST_FINAL) && (st_n == ST_RUN));
      if (st_q == ST_IDLE) mode_q <= mode_sel;
    end
  end

  // R2: one LSB at most per cycle
  p_one_lsb_r2: assert property (@(posedge clk) disable iff (rst)
    $past(en) |-> ((code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1) ||
                   (code_q + 1'b1 == $past(code_q))));

  // R9: flags exclusive and completion sticky while enabled
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(active_q && done_q));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(done_q)) |-> done_q);

  // R3: completion is declared on a tick that does not move the code
  p_done_at_rest_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $stable(code_q));

  // R5: boot path never passes the boot level
  p_boot_cap_r5: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_BOOT) || (st_q == ST_PAUSE)) |-> (code_q <= BOOT_V));

endmodule

// File: rtl/dac_ramp_top.sv
module dac_ramp_top
  import ssr_pkg::*;
#(
  parameter int CODE_W             = 8,
  parameter int PER_W              = 16,
  parameter int RATE_W             = 2,
  parameter int SS_PERIOD          = 64,
  parameter int SLEW_PERIOD_DIRECT = 16,
  parameter int SLEW_PERIOD_BOOT   = 32,
  parameter int BOOT_CODE          = 100,
  parameter int PAUSE_CYC          = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [CODE_W-1:0] vid_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              ss_active,
  output logic              ss_done
);

  localparam logic [PER_W-1:0] SS_P  = PER_W'(SS_PERIOD);
  localparam logic [PER_W-1:0] SLD_P = PER_W'(SLEW_PERIOD_DIRECT);
  localparam logic [PER_W-1:0] SLB_P = PER_W'(SLEW_PERIOD_BOOT);

  logic [CODE_W-1:0] vid_acc;
  logic              vid_chg;
  logic              tick, phase_rst, mode_q;
  logic [PER_W-1:0]  base_per, step_per;

  vid_filter #(.CODE_W(CODE_W)) u_filt (
    .clk     (clk),
    .rst     (rst),
    .vid_in  (vid_in),
    .vid_acc (vid_acc),
    .vid_chg (vid_chg)
  );

  always_comb begin
    if (!ss_done)   base_per = SS_P;
    else if (mode_q) base_per = SLB_P;
    else            base_per = SLD_P;
    step_per = base_per << rate_sel;
  end

  step_osc #(.PER_W(PER_W)) u_osc (
    .clk    (clk),
    .rst    (rst),
    .clr    (phase_rst || vid_chg || !en),
    .period (step_per),
    .tick   (tick)
  );

  ramp_seq #(
    .CODE_W    (CODE_W),
    .BOOT_CODE (BOOT_CODE),
    .PAUSE_CYC (PAUSE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode_sel  (mode_sel),
    .vid_tgt   (vid_acc),
    .tick      (tick),
    .code_q    (dac_code),
    .active_q  (ss_active),
    .done_q    (ss_done),
    .mode_q    (mode_q),
    .phase_rst (phase_rst)
  );

endmodule

// File: tb/dac_ramp_top_tb_top.sv
`timescale 1ns/1ps
module dac_ramp_top_tb_top;

  localparam int CW   = 8;
  localparam int RW   = 2;
  localparam int SSP  = 4;
  localparam int SLD  = 2;
  localparam int SLB  = 3;
  localparam int BOOT = 40;
  localparam int PW   = 50;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          mode_sel = 1'b0;
  logic [RW-1:0] rate_sel = '0;
  logic [CW-1:0] vid_in = '0;
  logic [CW-1:0] dac_code;
  logic          ss_active, ss_done;

  int nvec = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  dac_ramp_top #(
    .CODE_W(CW), .PER_W(8), .RATE_W(RW), .SS_PERIOD(SSP),
    .SLEW_PERIOD_DIRECT(SLD), .SLEW_PERIOD_BOOT(SLB),
    .BOOT_CODE(BOOT), .PAUSE_CYC(PW)
  ) dut_i (
    .clk(clk), .rst(rst), .en(en), .mode_sel(mode_sel), .rate_sel(rate_sel),
    .vid_in(vid_in), .dac_code(dac_code), .ss_active(ss_active), .ss_done(ss_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int iabs(input int a);
    return (a < 0) ? -a : a;
  endfunction

  // expected code after edge j of a start-up, final target t, period p
  function automatic int ramp_code(input bit boot, input int j, input int t, input int p);
    int jb, jf, d, m;
    if (!boot) return imin(j / p, t);
    jb = (BOOT + 1) * p;
    if (j < jb) return imin(j / p, BOOT);
    if (j < jb + PW) return BOOT;
    jf = j - jb - PW;
    d  = iabs(t - BOOT);
    m  = imin(jf / p, d);
    return (t >= BOOT) ? BOOT + m : BOOT - m;
  endfunction

  function automatic int done_at(input bit boot, input int t, input int p);
    if (!boot) return (t + 1) * p;
    return (BOOT + 1) * p + PW + (iabs(t - BOOT) + 1) * p;
  endfunction

  task automatic disable_blk();
    en = 1'b0;
    @(negedge clk);
    chk("R1 code", dac_code, 0);
    chk("R1 active", ss_active, 0);
    chk("R1 done", ss_done, 0);
  endtask

  // start-up; optional VID change applied after edge late_j (R5)
  task automatic run_start(input bit boot, input int rate, input int t,
                           input int late_t, input int late_j);
    int p, tf, jd, prev;
    p  = SSP << rate;
    tf = (late_j >= 0) ? late_t : t;
    jd = done_at(boot, tf, p);
    disable_blk();
    vid_in = CW'(t);
    repeat (5) @(negedge clk);
    mode_sel = boot;
    rate_sel = RW'(rate);
    en = 1'b1;
    prev = 0;
    for (int j = 0; j <= jd + 2; j++) begin
      @(negedge clk);
      chk(boot ? "R4/R6 code" : "R3/R6 code", dac_code, ramp_code(boot, j, tf, p));
      chk("R2 step", int'(iabs(int'(dac_code) - prev) <= 1), 1);
      chk(boot ? "R4 done" : "R3 done", ss_done, int'(j >= jd));
      chk("R9 active", ss_active, int'(j < jd));
      prev = dac_code;
      if (j == late_j) vid_in = CW'(late_t);
    end
  endtask

  // R7 / R10: slew after soft-start, new VID first present at edge 0
  task automatic run_slew(input int t, input int t2);
    int ps, d, s;
    ps = (mode_sel ? SLB : SLD) << rate_sel;
    d  = iabs(t2 - t);
    s  = (t2 >= t) ? 1 : -1;
    vid_in = CW'(t2);
    for (int j = 0; j <= 3 + (d + 1) * ps; j++) begin
      @(negedge clk);
      chk("R7 slew code", dac_code, (j < 3) ? t : t + s * imin((j - 3) / ps, d));
    end
    chk("R10 settle", dac_code, t2);
    chk("R9 done held", ss_done, 1);
  endtask

  task automatic run_glitch(input int t);
    vid_in = CW'(t ^ 1);
    @(negedge clk);
    vid_in = CW'(t);
    repeat (30) begin
      @(negedge clk);
      chk("R8 glitch ignored", dac_code, t);
    end
  endtask

  // R11: VID acceptance on the same edge that completes soft-start
  task automatic run_collide(input int rate, input int t, input int t2);
    int p, ps, jd, d, s, exp;
    p  = SSP << rate;
    ps = SLD << rate;
    jd = done_at(1'b0, t, p);
    d  = iabs(t2 - t);
    s  = (t2 >= t) ? 1 : -1;
    disable_blk();
    vid_in = CW'(t);
    repeat (5) @(negedge clk);
    mode_sel = 1'b0;
    rate_sel = RW'(rate);
    en = 1'b1;
    for (int j = 0; j <= jd + (d + 1) * ps + 2; j++) begin
      @(negedge clk);
      exp = (j < jd) ? ramp_code(1'b0, j, t, p) : t + s * imin((j - jd) / ps, d);
      chk("R11 code", dac_code, exp);
      chk("R11 done", ss_done, int'(j >= jd));
      if (j == jd - 4) vid_in = CW'(t2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int tl[5] = '{0, 3, 40, 97, 255};
    repeat (3) @(negedge clk);
    chk("R1 reset code", dac_code, 0);
    chk("R1 reset active", ss_active, 0);
    chk("R1 reset done", ss_done, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 4; r++) begin
        foreach (tl[i]) begin
          run_start(m[0], r, tl[i], 0, -1);
          if (r < 2) begin
            run_slew(tl[i], (tl[i] + 23) % 256);
            run_slew((tl[i] + 23) % 256, tl[i]);
          end
          if (r == 0) run_glitch(tl[i]);
        end
      end
    end

    // R5: VID moved during the pause, boot path unaffected
    run_start(1'b1, 0, 200, 10, (BOOT + 1) * SSP + 1);
    run_start(1'b1, 1, 3, 120, (BOOT + 1) * (SSP << 1) + 1);

    run_collide(0, 10, 5);
    run_collide(2, 6, 30);

    disable_blk();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule